// File: doc/BRIEF.md
# Prioritized Interrupt Delivery Unit

This block sits next to a simple in-order processor core. It turns asynchronous interrupt events into exception requests that the core takes at instruction boundaries. It has three event sources:

- a reset-request line;
- a non-maskable interrupt (NMI) line;
- a vector of maskable interrupt levels, one bit per interrupt-pending position IP[5:0].

Each event sets a sticky pending flag. Maskable level bits are merged into the pending vector by OR.

The core pulses `instr_done_i` when an instruction retires. In that cycle the block picks at most one pending request, by fixed priority: reset request, then NMI, then maskable levels. A reset request or an NMI raises the shared NMI/reset exception request. A maskable request goes out only when the core's current interrupt-enable bit is set and the status-register mask field leaves at least one pending level bit through. A maskable request that is blocked stays pending and is tried again at every later boundary. The block never writes the cause register, so the core may see its IP field as zero when its handler runs.

Top module: `irq_delivery_unit`

## Requirements
- R1: While `rst_n` is low, at the next rising clock edge every pending flag (reset request, NMI, all level bits) is cleared, so a following boundary with interrupts enabled and every mask bit set raises no request.
- R2: A pending reset request has highest priority and raises `nmi_reset_exc_o`. Serving it clears only the reset-request flag: a pending NMI raises `nmi_reset_exc_o` again at the next boundary.
- R3: A pending NMI raises `nmi_reset_exc_o` ahead of any pending maskable level. The maskable request follows at a later boundary.
- R4: Level bits arriving in different cycles accumulate by OR in the pending vector. A bit stays set until a maskable delivery clears it.
- R5: `int_exc_o` is raised only when `ie_cur_i` is 1 and the bitwise AND of the pending vector with `im_i` is nonzero. Bit i of `im_i` enables bit i of `level_i`.
- R6: A maskable delivery clears the whole pending vector, including bits that `im_i` masked at that moment.
- R7: Maskable bits that are pending but blocked (disabled or masked) are kept and re-evaluated at every later boundary. They are delivered as soon as the enable and mask allow it.
- R8: Requests are raised only in cycles where `instr_done_i` is 1. An event that arrives in a boundary cycle is first evaluated at the next boundary.
- R9: `nmi_reset_exc_o` and `int_exc_o` are one-cycle pulses and are never high in the same cycle.
- R10: If an event arrives in the same cycle in which its pending flag is cleared by a delivery, the new event wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset; clears all pending state |
| reset_req_i | input | 1 | Reset-request event (one-cycle pulse sets the flag) |
| nmi_i | input | 1 | Non-maskable interrupt event |
| level_i | input | LEVEL_W | Maskable interrupt level events, bit i = IP[i] |
| instr_done_i | input | 1 | Instruction-boundary strobe from the core |
| ie_cur_i | input | 1 | Current interrupt-enable bit from the status register |
| im_i | input | LEVEL_W | Interrupt mask field from the status register |
| nmi_reset_exc_o | output | 1 | Combined NMI/reset exception request pulse |
| int_exc_o | output | 1 | Maskable interrupt exception request pulse |

## Verification
The hardest state to reach from the ports is a flag being cleared by a delivery in the same cycle that a new event for that flag arrives. There is also no status output, so the pending vector is visible only through later deliveries. The stimulus drives an event on the very boundary cycle that serves the old one. It then proves the flag survived with a second boundary whose mask admits only the new bit. Masked bits being discarded on delivery is shown the same way: a boundary with every mask bit open raises nothing afterwards.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef enum logic [1:0] {
      PICK_NONE = 2'd0,
      PICK_RST  = 2'd1,
      PICK_NMI  = 2'd2,
      PICK_LVL  = 2'd3
   } pick_e;

endpackage

// File: rtl/irq_flag_store.sv
module irq_flag_store #(
   parameter int LEVEL_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rst_req_set_i,
   input  logic               nmi_set_i,
   input  logic [LEVEL_W-1:0] lvl_set_i,
   input  logic               rst_req_clr_i,
   input  logic               nmi_clr_i,
   input  logic               lvl_clr_i,
   output logic               rst_req_pend_o,
   output logic               nmi_pend_o,
   output logic [LEVEL_W-1:0] lvl_pend_o
);

   logic rst_req_q;
   logic nmi_q;

   // set has priority over clear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_req_q <= 1'b0;
         nmi_q     <= 1'b0;
      end else begin
         rst_req_q <= (rst_req_q & ~rst_req_clr_i) | rst_req_set_i;
         nmi_q     <= (nmi_q & ~nmi_clr_i) | nmi_set_i;
      end
   end

   for (genvar b = 0; b < LEVEL_W; b++) begin : g_lvl
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= (bit_q & ~lvl_clr_i) | lvl_set_i[b];
      end
      assign lvl_pend_o[b] = bit_q;
   end

   assign rst_req_pend_o = rst_req_q;
   assign nmi_pend_o     = nmi_q;

   // R10
   nmi_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_set_i |=> nmi_pend_o);

   // R10
   rst_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_set_i |=> rst_req_pend_o);

   // R4
   lvl_accum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|lvl_set_i) |=> ((lvl_pend_o & $past(lvl_set_i)) == $past(lvl_set_i)));

endmodule

// File: rtl/irq_pick.sv
module irq_pick
   import irq_pkg::*;
#(
   parameter int LEVEL_W = 6
) (
   input  logic               boundary_i,
   input  logic               rst_req_pend_i,
   input  logic               nmi_pend_i,
   input  logic [LEVEL_W-1:0] lvl_pend_i,
   input  logic               ie_i,
   input  logic [LEVEL_W-1:0] im_i,
   output pick_e              pick_o
);

   logic lvl_ok;

   assign lvl_ok = ie_i & (|(lvl_pend_i & im_i));

   always_comb begin
      pick_o = PICK_NONE;
      if (boundary_i) begin
         if (rst_req_pend_i)  pick_o = PICK_RST;
         else if (nmi_pend_i) pick_o = PICK_NMI;
         else if (lvl_ok)     pick_o = PICK_LVL;
      end
   end

endmodule

// File: rtl/irq_delivery_unit.sv
module irq_delivery_unit
   import irq_pkg::*;
#(
   parameter int LEVEL_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reset_req_i,
   input  logic               nmi_i,
   input  logic [LEVEL_W-1:0] level_i,
   input  logic               instr_done_i,
   input  logic               ie_cur_i,
   input  logic [LEVEL_W-1:0] im_i,
   output logic               nmi_reset_exc_o,
   output logic               int_exc_o
);

   if (LEVEL_W < 1 || LEVEL_W > 32) begin : g_bad_width
      $error("irq_delivery_unit: LEVEL_W must be 1..32");
   end

   logic               rst_req_pend;
   logic               nmi_pend;
   logic [LEVEL_W-1:0] lvl_pend;
   pick_e              pick;

   irq_flag_store #(.LEVEL_W(LEVEL_W)) u_store (
      .clk            (clk),
      .rst_n          (rst_n),
      .rst_req_set_i  (reset_req_i),
      .nmi_set_i      (nmi_i),
      .lvl_set_i      (level_i),
      .rst_req_clr_i  (pick == PICK_RST),
      .nmi_clr_i      (pick == PICK_NMI),
      .lvl_clr_i      (pick == PICK_LVL),
      .rst_req_pend_o (rst_req_pend),
      .nmi_pend_o     (nmi_pend),
      .lvl_pend_o     (lvl_pend)
   );

   irq_pick #(.LEVEL_W(LEVEL_W)) u_pick (
      .boundary_i     (instr_done_i),
      .rst_req_pend_i (rst_req_pend),
      .nmi_pend_i     (nmi_pend),
      .lvl_pend_i     (lvl_pend),
      .ie_i           (ie_cur_i),
      .im_i           (im_i),
      .pick_o         (pick)
   );

   assign nmi_reset_exc_o = (pick == PICK_RST) || (pick == PICK_NMI);
   assign int_exc_o       = (pick == PICK_LVL);

   // R9
   excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nmi_reset_exc_o && int_exc_o));

   // R8
   boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_done_i |-> !(nmi_reset_exc_o || int_exc_o));

   // R5
   int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_exc_o |-> (ie_cur_i && (|(lvl_pend & im_i))));

   // R6
   lvl_clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_exc_o |=> (lvl_pend == $past(level_i)));

   // R2
   nmi_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_done_i && rst_req_pend && nmi_pend) |=> nmi_pend);

   // R3
   nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_pend && instr_done_i) |-> (nmi_reset_exc_o && !int_exc_o));

endmodule

// File: tb/irq_delivery_unit_bench.sv
module irq_delivery_unit_bench;

   localparam int LW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reset_req_i = 1'b0;
   logic          nmi_i = 1'b0;
   logic [LW-1:0] level_i = '0;
   logic          instr_done_i = 1'b0;
   logic          ie_cur_i = 1'b0;
   logic [LW-1:0] im_i = '0;
   logic          nmi_reset_exc_o;
   logic          int_exc_o;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   irq_delivery_unit #(.LEVEL_W(LW)) u_irq_delivery_unit (
      .clk(clk), .rst_n(rst_n), .reset_req_i(reset_req_i), .nmi_i(nmi_i),
      .level_i(level_i), .instr_done_i(instr_done_i), .ie_cur_i(ie_cur_i),
      .im_i(im_i), .nmi_reset_exc_o(nmi_reset_exc_o), .int_exc_o(int_exc_o)
   );

   typedef struct packed {
      logic          ev_rst;
      logic          ev_nmi;
      logic [LW-1:0] ev_lvl;
      logic          ie;
      logic [LW-1:0] im;
      logic          exp_nr;
      logic          exp_int;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 6'h01, 1'b1, 6'h01, 1'b0, 1'b1},  // R5 deliver
      '{1'b0, 1'b0, 6'h02, 1'b0, 6'h3F, 1'b0, 1'b0},  // R5 ie low
      '{1'b0, 1'b0, 6'h00, 1'b1, 6'h01, 1'b0, 1'b0},  // R5 masked
      '{1'b0, 1'b0, 6'h00, 1'b1, 6'h02, 1'b0, 1'b1},  // R7 retried
      '{1'b0, 1'b0, 6'h04, 1'b0, 6'h3F, 1'b0, 1'b0},  // R4 first bit
      '{1'b0, 1'b0, 6'h08, 1'b0, 6'h3F, 1'b0, 1'b0},  // R4 second bit
      '{1'b0, 1'b0, 6'h00, 1'b1, 6'h04, 1'b0, 1'b1},  // R4 first bit kept
      '{1'b0, 1'b0, 6'h00, 1'b1, 6'h3F, 1'b0, 1'b0},  // R6 all cleared
      '{1'b0, 1'b1, 6'h10, 1'b1, 6'h3F, 1'b1, 1'b0},  // R3 nmi first
      '{1'b0, 1'b0, 6'h00, 1'b1, 6'h3F, 1'b0, 1'b1},  // R3 level next
      '{1'b1, 1'b1, 6'h00, 1'b1, 6'h3F, 1'b1, 1'b0},  // R2 reset req
      '{1'b0, 1'b0, 6'h00, 1'b1, 6'h3F, 1'b1, 1'b0},  // R2 nmi kept
      '{1'b0, 1'b0, 6'h00, 1'b1, 6'h3F, 1'b0, 1'b0},  // R2 both served
      '{1'b1, 1'b0, 6'h20, 1'b1, 6'h20, 1'b1, 1'b0},  // R2 reset over level
      '{1'b0, 1'b0, 6'h00, 1'b1, 6'h20, 1'b0, 1'b1},  // R2 level after
      '{1'b0, 1'b0, 6'h21, 1'b1, 6'h01, 1'b0, 1'b1},  // R6 partial mask
      '{1'b0, 1'b0, 6'h00, 1'b1, 6'h3F, 1'b0, 1'b0}   // R6 masked bit gone
   };

   task automatic check(input string req, input logic act_nr, input logic act_int,
                        input logic exp_nr, input logic exp_int);
      total++;
      if (act_nr !== exp_nr || act_int !== exp_int) begin
         bad++;
         $display("FAIL %s: nr/int actual=%b%b expected=%b%b", req, act_nr, act_int,
                  exp_nr, exp_int);
      end
   endtask

   // events in one cycle, then one boundary cycle sampled before its edge
   task automatic step(input string req, input vec_t v);
      @(negedge clk);
      reset_req_i = v.ev_rst; nmi_i = v.ev_nmi; level_i = v.ev_lvl;
      instr_done_i = 1'b0;
      #1 check({req, " R8 no pulse off boundary"}, nmi_reset_exc_o, int_exc_o, 1'b0, 1'b0);
      @(negedge clk);
      reset_req_i = 1'b0; nmi_i = 1'b0; level_i = '0;
      instr_done_i = 1'b1; ie_cur_i = v.ie; im_i = v.im;
      #1 check(req, nmi_reset_exc_o, int_exc_o, v.exp_nr, v.exp_int);
      total++;
      if (nmi_reset_exc_o && int_exc_o) begin
         bad++;
         $display("FAIL R9: both outputs high actual=11 expected not both");
      end
   endtask

   task automatic boundary(input string req, input logic ie, input logic [LW-1:0] im,
                           input logic en, input logic ei);
      @(negedge clk);
      reset_req_i = 1'b0; nmi_i = 1'b0; level_i = '0;
      instr_done_i = 1'b1; ie_cur_i = ie; im_i = im;
      #1 check(req, nmi_reset_exc_o, int_exc_o, en, ei);
      @(negedge clk);
      instr_done_i = 1'b0;
      #1 check({req, " R9 one-cycle pulse"}, nmi_reset_exc_o, int_exc_o, 1'b0, 1'b0);
   endtask

   initial begin
      #100000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      boundary("R1 after reset", 1'b1, 6'h3F, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) step($sformatf("vec%0d", i), VECS[i]);

      // R1: pending nmi and level wiped by block reset
      @(negedge clk); nmi_i = 1'b1; level_i = 6'h3F;
      @(negedge clk); nmi_i = 1'b0; level_i = '0; rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      boundary("R1 pending cleared", 1'b1, 6'h3F, 1'b0, 1'b0);

      // R8: event arriving in a boundary cycle waits for the next boundary
      @(negedge clk); nmi_i = 1'b1; instr_done_i = 1'b1;
      #1 check("R8 same-cycle event", nmi_reset_exc_o, int_exc_o, 1'b0, 1'b0);
      @(negedge clk); nmi_i = 1'b0; instr_done_i = 1'b0;
      boundary("R8 next boundary", 1'b1, 6'h3F, 1'b1, 1'b0);

      // R10: nmi re-raised in the cycle its flag is served
      @(negedge clk); nmi_i = 1'b1;
      @(negedge clk); instr_done_i = 1'b1;
      #1 check("R10 nmi served", nmi_reset_exc_o, int_exc_o, 1'b1, 1'b0);
      @(negedge clk); nmi_i = 1'b0; instr_done_i = 1'b0;
      boundary("R10 nmi kept", 1'b1, 6'h3F, 1'b1, 1'b0);
      boundary("R10 nmi drained", 1'b1, 6'h3F, 1'b0, 1'b0);

      // R10: level bit arriving while the vector is cleared by delivery
      @(negedge clk); level_i = 6'h01;
      @(negedge clk); level_i = 6'h02; instr_done_i = 1'b1; ie_cur_i = 1'b1; im_i = 6'h01;
      #1 check("R10 level served", nmi_reset_exc_o, int_exc_o, 1'b0, 1'b1);
      @(negedge clk); level_i = '0; instr_done_i = 1'b0;
      boundary("R10 new level kept", 1'b1, 6'h02, 1'b0, 1'b1);

      // R7: blocked for many boundaries, then delivered
      @(negedge clk); level_i = 6'h08;
      @(negedge clk); level_i = '0;
      for (int k = 0; k < 4; k++) boundary("R7 blocked", 1'b0, 6'h08, 1'b0, 1'b0);
      boundary("R7 released", 1'b1, 6'h08, 1'b0, 1'b1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule